// File: doc/BRIEF.md
# Four-Beat Burst Memory with Independent Read and Write Ports

This block is a synthesizable behavioural model of a memory with separate read and write command ports. Every access moves a fixed burst of four words. A single beat clock runs at twice the command rate. The input `k_phase` is high on beats that stand for the rising edge of the command clock (the "command beat") and low on the half-cycle beats in between. Commands are taken only on command beats. Data moves on every beat, so a burst of four spans two command cycles.

Both ports share one address bus, which carries a burst address. The read port takes its address on the command beat. The write port takes its address on the beat that follows. A read and a write can therefore start in the same command cycle. Writes are masked per 9-bit byte lane. Read data comes out three beats after the read command, together with a valid flag that stands in for the output driver enable. The array depth is a parameter, so simulations can use a small array.

Top module: `burst4_sram`

## Requirements
- R1: `rd_sel_n` and `wr_sel_n` are active low and are sampled only on beats where `k_phase` is 1. On beats where `k_phase` is 0 they are ignored.
- R2: An accepted read command at beat edge E returns word 0 of its burst on `rdata` after edge E+3, then words 1, 2 and 3 after edges E+4, E+5 and E+6.
- R3: `rdata_vld` is 1 exactly on the four beats that carry read words and 0 otherwise. While reset is held, `rdata_vld` and `rdata` are 0.
- R4: An accepted write command at edge E takes its burst address from `addr` at edge E+1. It stores the `wdata` presented at edges E+1, E+2, E+3 and E+4 as words 0, 1, 2 and 3.
- R5: Bit i of `byte_en_n` qualifies `wdata` bits [9i+8:9i] on the same beat. With the default of two lanes, bit 0 covers bits 8:0 and bit 1 covers bits 17:9. A lane whose bit is 1 is not written, and the stored byte keeps its old value.
- R6: A read command on the command beat directly after an accepted read (two edges later) is ignored. A read accepted four edges after another follows it with no gap on `rdata_vld`.
- R7: A write command during a write burst is ignored, except on the burst's last data beat, where a new write may be accepted.
- R8: Raising `rd_sel_n` after a read has been accepted does not shorten that read burst.
- R9: `addr` is ignored on any beat where the port that would use it is idle. Such beats leave the stored contents unchanged.
- R10: A read and a write accepted on the same command beat are both carried out. Each read word reflects every write to that word that happened at or before the edge two beats before the word is driven.
- R11: Word w (0 to 3) of the burst at burst address A lives at word index 4*A + w. Burst addresses are `ADDR_W` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_phase | input | 1 | 1 on command beats (rising command clock) |
| rd_sel_n | input | 1 | Read command, active low |
| wr_sel_n | input | 1 | Write command, active low |
| addr | input | ADDR_W | Shared burst address |
| wdata | input | BYTE_W*NUM_BYTES | Write data for the current beat |
| byte_en_n | input | NUM_BYTES | Per-lane write mask, active low |
| rdata | output | BYTE_W*NUM_BYTES | Read data for the current beat |
| rdata_vld | output | 1 | High while a read word is driven |

## Verification
Read word w of a command accepted at edge E is due on the output after edge E+3+w, and `rdata_vld` is due on exactly those four edges. The bench keeps a slot table of the edges at which words are expected. It compares `rdata_vld` after every edge, and compares `rdata` wherever a slot is due, sampling 1 ns after the edge. Writes become visible one edge after their data beat. The reference array is updated in that same edge order, after the edge's read slot has been resolved. Write masking, ignored commands and idle addresses therefore show up in the words read back later.

// File: rtl/b4_sram_pkg.sv
package b4_sram_pkg;
  // words carried by one burst and the index width that addresses them
  localparam int BURST_LEN   = 4;
  localparam int BEAT_IDX_W  = $clog2(BURST_LEN);
  // command beat to first read word, in beats
  localparam int RD_PIPE     = 3;
endpackage

// File: rtl/b4_lane.sv
module b4_lane #(
  parameter int BYTE_W  = 9,
  parameter int WORD_AW = 7
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  logic [BYTE_W-1:0]  wbyte,
  input  logic [WORD_AW-1:0] raddr,
  output logic [BYTE_W-1:0]  rbyte
);
  localparam int DEPTH = 1 << WORD_AW;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wbyte;
  end

  assign rbyte = mem_q[raddr];
endmodule

// File: rtl/b4_wr_engine.sv
module b4_wr_engine
  import b4_sram_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int NUM_BYTES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         k_phase,
  input  logic                         wr_sel_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_BYTES-1:0]         byte_en_n,
  output logic [NUM_BYTES-1:0]         lane_we,
  output logic [ADDR_W+BEAT_IDX_W-1:0] waddr_word
);
  localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(BURST_LEN - 1);

  logic                  run_q, run_d;
  logic [BEAT_IDX_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0]     base_q, base_d;
  logic                  wr_acc;
  logic [ADDR_W-1:0]     cur_base;

  // a new write is taken on a command beat when idle or on the last data beat
  assign wr_acc   = k_phase & ~wr_sel_n & (~run_q | (cnt_q == LAST_BEAT));
  // the address arrives with data word 0, one beat after the command
  assign cur_base = (cnt_q == '0) ? addr : base_q;

  assign lane_we    = run_q ? ~byte_en_n : '0;
  assign waddr_word = {cur_base, cnt_q};

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == '0)       base_d = addr;
      if (cnt_q == LAST_BEAT) run_d = 1'b0;
    end
    if (wr_acc) begin
      run_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
    end
  end

  // R4: an accepted write occupies the next four data beats
  assert_wr_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> run_q ##1 run_q ##1 run_q ##1 run_q);

  // R7: a write request in mid-burst does not restart the beat count
  assert_wr_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != LAST_BEAT && k_phase && !wr_sel_n)
      |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/b4_rd_engine.sv
module b4_rd_engine
  import b4_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         k_phase,
  input  logic                         rd_sel_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic [ADDR_W+BEAT_IDX_W-1:0] mem_raddr,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rdata_vld
);
  localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(BURST_LEN - 1);
  localparam int LAST_STG = RD_PIPE - 1;

  logic [RD_PIPE-1:0]    stg_vld_q;
  logic [ADDR_W-1:0]     stg_addr_q [RD_PIPE];
  logic                  rd_acc, load;
  logic                  ob_run_q, ob_run_d;
  logic [BEAT_IDX_W-1:0] ob_cnt_q, ob_cnt_d;
  logic [ADDR_W-1:0]     ob_addr_q, ob_addr_d;
  logic [DATA_W-1:0]     rdata_q, rdata_d;
  logic                  vld_q, vld_d;

  // stage 1 holds a read taken one command cycle ago: block the next command beat
  assign rd_acc = k_phase & ~rd_sel_n & ~stg_vld_q[1];
  assign load   = stg_vld_q[LAST_STG];

  assign mem_raddr = load ? {stg_addr_q[LAST_STG], {BEAT_IDX_W{1'b0}}}
                          : {ob_addr_q, ob_cnt_q};

  always_comb begin
    ob_run_d  = ob_run_q & (ob_cnt_q != LAST_BEAT);
    ob_cnt_d  = ob_run_q ? ob_cnt_q + 1'b1 : ob_cnt_q;
    ob_addr_d = ob_addr_q;
    if (load) begin
      ob_run_d  = 1'b1;
      ob_cnt_d  = BEAT_IDX_W'(1);
      ob_addr_d = stg_addr_q[LAST_STG];
    end
    vld_d   = load | ob_run_q;
    rdata_d = vld_d ? mem_rdata : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld_q     <= '0;
      stg_addr_q[0] <= '0;
    end else begin
      stg_vld_q <= {stg_vld_q[RD_PIPE-2:0], rd_acc};
      if (rd_acc) stg_addr_q[0] <= addr;
    end
  end

  for (genvar s = 1; s < RD_PIPE; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_addr_q[s] <= '0;
      else if (stg_vld_q[s-1]) stg_addr_q[s] <= stg_addr_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_run_q  <= 1'b0;
      ob_cnt_q  <= '0;
      ob_addr_q <= '0;
      rdata_q   <= '0;
      vld_q     <= 1'b0;
    end else begin
      ob_run_q  <= ob_run_d;
      ob_cnt_q  <= ob_cnt_d;
      ob_addr_q <= ob_addr_d;
      rdata_q   <= rdata_d;
      vld_q     <= vld_d;
    end
  end

  assign rdata     = rdata_q;
  assign rdata_vld = vld_q;

  // R6: a burst reaching the output never collides with one still running
  assert_rd_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !ob_run_q);

  // R2: the pipeline tail turns into a driven word on the next beat
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rdata_vld);

  // R3 / R8: once driven, a burst stays valid for all four beats
  assert_vld_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata_vld) |=> rdata_vld ##1 rdata_vld ##1 rdata_vld);
endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
  import b4_sram_pkg::*;
#(
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2,
  parameter int ADDR_W    = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          k_phase,
  input  logic                          rd_sel_n,
  input  logic                          wr_sel_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BYTE_W*NUM_BYTES-1:0]   wdata,
  input  logic [NUM_BYTES-1:0]          byte_en_n,
  output logic [BYTE_W*NUM_BYTES-1:0]   rdata,
  output logic                          rdata_vld
);
  localparam int DATA_W  = BYTE_W * NUM_BYTES;
  localparam int WORD_AW = ADDR_W + BEAT_IDX_W;

  logic                 rst_meta_q, rst_sync_q;
  logic [NUM_BYTES-1:0] lane_we;
  logic [WORD_AW-1:0]   waddr_word, raddr_word;
  logic [DATA_W-1:0]    rd_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  b4_wr_engine #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_wr (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .k_phase    (k_phase),
    .wr_sel_n   (wr_sel_n),
    .addr       (addr),
    .byte_en_n  (byte_en_n),
    .lane_we    (lane_we),
    .waddr_word (waddr_word)
  );

  b4_rd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .k_phase   (k_phase),
    .rd_sel_n  (rd_sel_n),
    .addr      (addr),
    .mem_rdata (rd_word),
    .mem_raddr (raddr_word),
    .rdata     (rdata),
    .rdata_vld (rdata_vld)
  );

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    b4_lane #(.BYTE_W(BYTE_W), .WORD_AW(WORD_AW)) u_lane (
      .clk   (clk),
      .we    (lane_we[i]),
      .waddr (waddr_word),
      .wbyte (wdata[i*BYTE_W +: BYTE_W]),
      .raddr (raddr_word),
      .rbyte (rd_word[i*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: tb/burst4_sram_tb_top.sv
`timescale 1ns/1ps
module burst4_sram_tb_top;
  localparam int BW = 9;
  localparam int NB = 2;
  localparam int AW = 5;
  localparam int DW = BW * NB;
  localparam int NWORDS = 4 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          k_phase, rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [NB-1:0] byte_en_n;
  logic [DW-1:0] rdata;
  logic          rdata_vld;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst4_sram #(.BYTE_W(BW), .NUM_BYTES(NB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .byte_en_n(byte_en_n),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  // reference state
  logic [DW-1:0] ref_mem [NWORDS];
  bit  slot_v [16];
  int  slot_a [16];
  int  slot_w [16];
  bit  bw_run = 0;
  int  bw_cnt = 0;
  int  bw_base = 0;
  int  last_rd = -10;
  int  edge_n = 0;
  bit  ph = 1;

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // one beat: drive away from the edge, model the edge, sample 1 ns later
  task automatic beat(input bit rsn, input bit wsn, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [NB-1:0] ben);
    bit kph, exp_v, w_acc, r_acc;
    logic [DW-1:0] exp_d;
    int widx;
    kph = ph;
    @(negedge clk);
    k_phase = kph; rd_sel_n = rsn; wr_sel_n = wsn; addr = a; wdata = d; byte_en_n = ben;
    @(posedge clk);
    #1;
    // R2 R11: word due at this edge, read before this edge's write
    exp_v = slot_v[edge_n % 16];
    exp_d = '0;
    if (exp_v) exp_d = ref_mem[slot_a[edge_n % 16] * 4 + slot_w[edge_n % 16]];
    slot_v[edge_n % 16] = 0;
    // R1 R6 R7: acceptance from pre-edge state
    w_acc = kph && !wsn && (!bw_run || bw_cnt == 3);
    r_acc = kph && !rsn && (edge_n - last_rd != 2);
    // R4 R5 R9: write data beat
    if (bw_run) begin
      if (bw_cnt == 0) bw_base = int'(a);
      widx = bw_base * 4 + bw_cnt;
      for (int i = 0; i < NB; i++)
        if (!ben[i]) ref_mem[widx][i*BW +: BW] = d[i*BW +: BW];
      bw_run = (bw_cnt != 3);
      bw_cnt = bw_cnt + 1;
    end
    if (w_acc) begin bw_run = 1; bw_cnt = 0; end
    if (r_acc) begin
      last_rd = edge_n;
      for (int k = 0; k < 4; k++) begin
        slot_v[(edge_n + 3 + k) % 16] = 1;
        slot_a[(edge_n + 3 + k) % 16] = int'(a);
        slot_w[(edge_n + 3 + k) % 16] = k;
      end
    end
    check(rdata_vld == exp_v, "R3 R6 R8 output-enable", {{(DW-1){1'b0}}, rdata_vld}, {{(DW-1){1'b0}}, exp_v});
    if (exp_v) check(rdata === exp_d, "R2 R4 R5 R9 R10 R11 read data", rdata, exp_d);
    edge_n++;
    ph = ~ph;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(1, 1, AW'($urandom), DW'($urandom), NB'($urandom));
  endtask

  task automatic align();
    if (!ph) idle(1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) slot_v[i] = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; k_phase = 0; rd_sel_n = 1; wr_sel_n = 1; addr = '0; wdata = '0; byte_en_n = '1;
    repeat (4) @(posedge clk);
    #1;
    // R3: reset state
    check(rdata_vld == 1'b0, "R3 reset output-enable", {{(DW-1){1'b0}}, rdata_vld}, '0);
    check(rdata == '0, "R3 reset data", rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;
    ph = 1;
    idle(6);

    // fill every burst with full-lane writes (R4 R11)
    for (int b = 0; b < (1 << AW); b++) begin
      beat(1, 0, '0, DW'($urandom), '0);
      beat(1, 1, AW'(b), DW'($urandom), '0);
      beat(1, 1, '1, DW'($urandom), '0);
      beat(1, 1, '1, DW'($urandom), '0);
    end
    beat(1, 1, '1, DW'($urandom), '0);
    idle(3);

    // R10: read and write of the same burst in one command cycle, masked lanes (R5)
    align();
    beat(0, 0, 5'd3, DW'($urandom), '0);
    beat(1, 1, 5'd3, DW'($urandom), 2'b00);
    beat(1, 1, 5'd9, DW'($urandom), 2'b01);
    beat(1, 1, 5'd9, DW'($urandom), 2'b10);
    beat(1, 1, 5'd9, DW'($urandom), 2'b11);
    idle(7);

    // R8 R6 R1: read then deselect, repeat on K# and next command beat ignored
    align();
    beat(0, 1, 5'd7, '0, '1);
    beat(0, 1, 5'd8, '0, '1);
    beat(0, 1, 5'd9, '0, '1);
    beat(1, 1, 5'd9, '0, '1);
    idle(6);

    // R7: second write in mid-burst ignored, then read back burst 5
    align();
    beat(1, 0, '0, DW'($urandom), '0);
    beat(1, 1, 5'd5, DW'($urandom), '0);
    beat(1, 0, 5'd6, DW'($urandom), '0);
    beat(1, 1, 5'd6, DW'($urandom), '0);
    beat(0, 1, 5'd5, DW'($urandom), '0);
    idle(7);
    align();
    beat(0, 1, 5'd6, '0, '1);
    idle(7);

    // R6: back-to-back reads four beats apart
    align();
    beat(0, 1, 5'd1, '0, '1);
    idle(3);
    beat(0, 1, 5'd2, '0, '1);
    idle(9);

    // constrained random traffic
    for (int n = 0; n < 3000; n++)
      beat(($urandom % 3) == 0 ? 1'b1 : 1'b0, ($urandom % 3) == 0 ? 1'b1 : 1'b0,
           AW'($urandom), DW'($urandom), NB'($urandom));
    idle(10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule